// File: doc/BRIEF.md
# Bi-phase lighting-bus frame transmitter

This block turns one lighting-control frame into a bi-phase (Manchester) coded level on a single output wire. A host presents either a 16-bit forward word (address byte in the upper half, data byte in the lower half) or an 8-bit backward byte. A mode input picks between the two. The host loads the frame with a valid/ready handshake.

All timing is counted in half-bit units. The length of one unit is set by a parameter, `CLKS_PER_TE`, which gives the number of system clocks per half-bit. At 1200 bit/s one half-bit lasts about 416.67 µs. A frame is sent in this order:

- a start bit, coded as a logical one;
- the payload bits, most significant first;
- four half-bit units of idle-high stop level.

In the logic-side polarity, a one is high for the first half-bit and low for the second, and a zero is low then high. After every frame, the block keeps ready low for `GAP_TE` more half-bit units. This enforces the minimum idle time between frames on the bus.

Top module: `mbus_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is being sent, `line_out` is high and `busy` is low. `req_ready` is high after reset.
- R2: A request is accepted at a rising clock edge where both `req_valid` and `req_ready` are high. `busy` is high, and `req_ready` is low, from the following cycle onward.
- R3: With `req_fwd`=1, the frame is coded in 38 half-bit units. It carries a start bit of value 1, then `req_word[15]` down to `req_word[0]`. Each bit takes two units: a 1 is coded as high then low, and a 0 as low then high.
- R4: With `req_fwd`=0, the frame is coded in 22 half-bit units. It carries a start bit of value 1, then `req_word[7]` down to `req_word[0]`, with the same bit coding as R3. `req_word[15:8]` has no effect on the line.
- R5: Every half-bit unit lasts exactly `CLKS_PER_TE` clock cycles, counted from the acceptance edge. The line level is inverted at the tick in the middle of each start and payload bit.
- R6: After the last payload bit, the line stays high for 4 half-bit units. `busy` falls exactly 38 (forward) or 22 (backward) units after the acceptance edge.
- R7: After `busy` falls, `req_ready` stays low for exactly `GAP_TE` further half-bit units, and the line stays high during that time. `req_ready` then returns high.
- R8: A `req_valid` pulse raised while `req_ready` is low is ignored. It does not change the frame in progress and does not start a new frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request |
| req_ready | output | 1 | High when a request can be taken |
| req_fwd | input | 1 | 1 = 16-bit forward word, 0 = 8-bit backward byte |
| req_word | input | 16 | Payload; the backward byte uses bits 7:0 |
| busy | output | 1 | High while a frame (start, payload, stop) is on the line |
| line_out | output | 1 | Bi-phase coded output, idles high |

## Verification
The bench samples the line in the middle of every half-bit and compares it with a model of the bi-phase code. It uses both frame lengths and payloads made of all ones, all zeros, alternating bits, and mixed upper and lower bytes. A design that shifts LSb first, leaves out the mid-bit inversion, or reads the wrong byte in backward mode produces a wrong level in some half-bit. A design that miscounts the stop period, the frame length or the gap moves the falling edge of `busy` or the rising edge of `req_ready` by at least one clock, and the bench checks both edges to the exact cycle. Requests pulsed during a frame and during the gap catch a design that latches a request while not ready.

// File: rtl/mbus_tx_pkg.sv
package mbus_tx_pkg;
  localparam int FWD_BITS = 16;
  localparam int BWD_BITS = 8;
  localparam int STOP_TE  = 4;
  localparam int FWD_TE   = 2 * (FWD_BITS + 1) + STOP_TE;
  localparam int BWD_TE   = 2 * (BWD_BITS + 1) + STOP_TE;
  localparam int SH_W     = FWD_BITS + 1;
  localparam int BCNT_W   = $clog2(SH_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/mbus_te_timer.sv
module mbus_te_timer #(
  parameter int CLKS_PER_TE = 20833
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (CLKS_PER_TE > 1) ? $clog2(CLKS_PER_TE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_TE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: the divider never runs past the last count of a unit
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/mbus_bit_shifter.sv
module mbus_bit_shifter
  import mbus_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            fwd_i,
  input  logic [15:0]     word_i,
  input  logic            active_i,
  input  logic            tick_i,
  output logic            line_o
);
  logic [SH_W-1:0]   sh_q;
  logic [BCNT_W-1:0] left_q;
  logic              second_q;
  logic              line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      left_q   <= '0;
      second_q <= 1'b0;
      line_q   <= 1'b1;
    end else if (load_i) begin
      sh_q     <= fwd_i ? {1'b1, word_i} : {1'b1, word_i[7:0], 8'h00};
      left_q   <= fwd_i ? BCNT_W'(FWD_BITS + 1) : BCNT_W'(BWD_BITS + 1);
      second_q <= 1'b0;
      line_q   <= 1'b1;
    end else if (active_i && tick_i) begin
      if (left_q == '0) begin
        line_q <= 1'b1;
      end else if (!second_q) begin
        line_q   <= ~line_q;
        second_q <= 1'b1;
      end else begin
        second_q <= 1'b0;
        sh_q     <= sh_q << 1;
        left_q   <= left_q - 1'b1;
        line_q   <= (left_q > BCNT_W'(1)) ? sh_q[SH_W-2] : 1'b1;
      end
    end
  end

  assign line_o = line_q;

  // R5: the line moves only on a half-bit tick or on a load
  assert_line_moves_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_q) |-> $past(tick_i || load_i));
  // R5: mid-bit tick of a coded bit always inverts the line
  assert_midbit_invert_R5: assert property (@(posedge clk) disable iff (rst)
    (active_i && tick_i && !load_i && !second_q && left_q != '0) |=> (line_q != $past(line_q)));
  // R6: once every bit is out the line rests high
  assert_stop_high_R6: assert property (@(posedge clk) disable iff (rst)
    (left_q == '0 && !load_i) |=> line_q);
endmodule

// File: rtl/mbus_frame_tx.sv
module mbus_frame_tx
  import mbus_tx_pkg::*;
#(
  parameter int CLKS_PER_TE = 20833,
  parameter int GAP_TE      = 22
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_fwd,
  input  logic [15:0] req_word,
  output logic        busy,
  output logic        line_out
);
  localparam int MAXU   = (FWD_TE > GAP_TE) ? FWD_TE : GAP_TE;
  localparam int UNIT_W = $clog2(MAXU + 1);

  tx_state_t         state_q;
  logic [UNIT_W-1:0] units_q;
  logic [UNIT_W-1:0] frame_last_q;
  logic              accept;
  logic              tick;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_SEND);

  mbus_te_timer #(.CLKS_PER_TE(CLKS_PER_TE)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (accept),
    .run_i     (state_q != ST_IDLE),
    .tick_o    (tick)
  );

  mbus_bit_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .fwd_i    (req_fwd),
    .word_i   (req_word),
    .active_i (state_q == ST_SEND),
    .tick_i   (tick),
    .line_o   (line_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      units_q      <= '0;
      frame_last_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q      <= ST_SEND;
          units_q      <= '0;
          frame_last_q <= req_fwd ? UNIT_W'(FWD_TE - 1) : UNIT_W'(BWD_TE - 1);
        end
        ST_SEND: if (tick) begin
          if (units_q == frame_last_q) begin
            state_q <= ST_GAP;
            units_q <= '0;
          end else begin
            units_q <= units_q + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (units_q == UNIT_W'(GAP_TE - 1)) begin
            state_q <= ST_IDLE;
            units_q <= '0;
          end else begin
            units_q <= units_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: no frame on the line means the line idles high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line_out);
  // R2: a frame starts only from an accepted handshake
  assert_start_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid && req_ready));
  // R7: ready and busy are never high together
  assert_ready_busy_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && busy));
  // R7: after busy falls the gap follows, not idle
  assert_gap_after_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !req_ready);
endmodule

// File: tb/mbus_frame_tx_tb.sv
module mbus_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int C   = 4;
  localparam int GAP = 22;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic        req_fwd;
  logic [15:0] req_word;
  logic        busy;
  logic        line_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_frame_tx #(.CLKS_PER_TE(C), .GAP_TE(GAP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fwd(req_fwd), .req_word(req_word), .busy(busy), .line_out(line_out)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic model_level(input bit fwd, input logic [15:0] w, input int h);
    int nb = fwd ? 17 : 9;
    int b;
    logic v;
    if (h >= 2 * nb) return 1'b1;
    b = h / 2;
    if (b == 0) v = 1'b1;
    else v = fwd ? w[16 - b] : w[8 - b];
    return (h % 2 == 0) ? v : ~v;
  endfunction

  // Sends one frame and checks line, busy, ready cycle by cycle.
  // poke_at >= 0 pulses a bogus request at that cycle of the frame (R8).
  task automatic run_frame(input bit fwd, input logic [15:0] w, input int poke_at, input string name);
    int units = fwd ? 38 : 22;
    int total = units * C;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_fwd = fwd; req_word = w; req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        req_word  = ~w;
        req_fwd   = ~fwd;
        check("R2", busy, 1'b1, {name, " busy after accept"});
        check("R2", req_ready, 1'b0, {name, " ready after accept"});
      end
      if (k == poke_at) req_valid = 1'b1;
      if (k == poke_at + 1) req_valid = 1'b0;
      if (k % C == C / 2)
        check(fwd ? "R3" : "R4", line_out, model_level(fwd, w, k / C),
              $sformatf("%s half %0d", name, k / C));
      if (k % C == 0 && k > 0)
        check("R5", line_out, model_level(fwd, w, k / C),
              $sformatf("%s edge of half %0d", name, k / C));
      if (k == total - 1) check("R6", busy, 1'b1, {name, " busy at last unit"});
    end
    @(negedge clk);
    check("R6", busy, 1'b0, {name, " busy falls on time"});
    for (int g = 1; g < GAP * C; g++) begin
      @(negedge clk);
      if (g == poke_at) req_valid = 1'b1;
      if (g == poke_at + 1) req_valid = 1'b0;
      if (g % C == 1) check("R7", line_out, 1'b1, {name, " line high in gap"});
      if (g == GAP * C - 1) check("R7", req_ready, 1'b0, {name, " ready still low"});
    end
    @(negedge clk);
    check("R7", req_ready, 1'b1, {name, " ready returns"});
    if (poke_at >= 0) begin
      repeat (3 * C) @(negedge clk);
      check("R8", busy, 1'b0, {name, " ignored request started nothing"});
      check("R8", line_out, 1'b1, {name, " line idle after ignored request"});
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; req_valid = 1'b0; req_fwd = 1'b0; req_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", line_out, 1'b1, "line after reset");
    check("R1", busy, 1'b0, "busy after reset");
    check("R1", req_ready, 1'b1, "ready after reset");
    repeat (5) @(negedge clk);
    check("R1", line_out, 1'b1, "line idle without request");
  endtask

  initial begin
    test_reset();
    run_frame(1'b1, 16'hA5C3, -1, "fwd_mixed");
    run_frame(1'b1, 16'hFFFF, -1, "fwd_ones");
    run_frame(1'b1, 16'h0000, -1, "fwd_zeros");
    run_frame(1'b0, 16'h3C55, -1, "bwd_alt");
    run_frame(1'b0, 16'hFF00, -1, "bwd_upper_ignored");
    run_frame(1'b0, 16'h00FF, -1, "bwd_ones");
    run_frame(1'b1, 16'h8001, 9 * C + 1, "fwd_poke");
    run_frame(1'b0, 16'h0081, 5 * C + 2, "bwd_poke");
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule